// File: doc/BRIEF.md
# Cluster Steering Unit

This unit decides, once per cycle, which of the four execution clusters of a partitioned processor core receives the renamed instruction presented to it. Each source operand carries a used flag, a ready flag, a mask of the clusters that already hold a copy of its value, and the ID of the cluster that will produce it. The unit also sees one workload counter per cluster, a programmable imbalance threshold and a mode bit. It returns the chosen cluster together with the number of copy messages that must travel to that cluster.

Locality comes first and load balance second. If an operand is still being computed, the instruction follows its producer. If every operand is present, the candidates are the clusters with the lowest copy cost. In the default mode that cost is the number of copies. In the distance mode it is the farthest hop count any copy must travel on a four-node bidirectional ring. Among the candidates the least loaded cluster wins. When the load spread grows past the threshold, locality is dropped and the least loaded cluster overall is taken.

Top module: `cluster_steer`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `out_cluster` and `out_copies` change only in the cycle after a cycle with `in_valid` high, and hold their value otherwise.
- R2: While `rst_n` is low, `out_valid`, `out_cluster` and `out_copies` are all 0.
- R3: With `topo_mode`=0, every used operand ready and no override, the candidates are the clusters that need the fewest copies. A ready operand needs a copy at cluster c when bit c of its location mask (bits [s*4 +: 4] of `src_loc`) is 0.
- R4: With `topo_mode`=1, every used operand ready and no override, the cost of a candidate cluster c is taken over each used operand absent from c. For such an operand, the distance is the ring distance min(|h-c|, 4-|h-c|) from c to the nearest holder h. The cost is the largest of these distances, and the candidates are the clusters with the smallest cost.
- R5: When any used operand is not ready and there is no override, the sole candidate is the producer (bits [s*2 +: 2] of `src_prod`) of the lowest-indexed such operand.
- R6: The chosen cluster is the candidate with the smallest load (bits [c*6 +: 6] of `loads`). A tie in load goes to the lowest cluster index.
- R7: When the maximum load minus the minimum load is strictly greater than `imb_thr`, all clusters are candidates. A spread equal to the threshold does not trigger this.
- R8: With no used operand (`src_used`=0), all clusters are candidates. An operand whose used bit is 0 affects neither the cluster nor the copy count.
- R9: `out_copies` is the number of used operands absent from the chosen cluster. A not-ready operand counts as present only at its producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| src_used | input | 2 | Operand s exists |
| src_rdy | input | 2 | Operand s value already computed |
| src_loc | input | 8 | Holder mask per operand, bits [s*4 +: 4] |
| src_prod | input | 4 | Producer cluster per operand, bits [s*2 +: 2] |
| loads | input | 24 | Workload counter per cluster, bits [c*6 +: 6] |
| imb_thr | input | 6 | Imbalance threshold |
| topo_mode | input | 1 | 0: fewest copies, 1: shortest worst-case distance |
| out_valid | output | 1 | A decision is presented |
| out_cluster | output | 2 | Chosen cluster |
| out_copies | output | 2 | Copy messages needed for the chosen cluster |

## Verification
On every cycle the assertions check the parts of the decision that hold whatever the operands are. The picked cluster must lie in the candidate set and carry the minimum load among the candidates, with ties going to the lower index. The override and the zero-operand case must open the candidate set to all four clusters, a waiting operand must leave exactly one candidate, and the output register must follow the one-cycle timing. Whether the candidate set is the right one (fewest copies versus shortest worst-case hop distance, and which producer wins among several waiting operands) is shown only by the bench's scenarios. The same holds for the exact copy count and the boundary where the load spread equals the threshold. The bench compares all of these against its own model.

// File: rtl/steer_pkg.sv
package steer_pkg;

  // Hop count between two nodes of an n-node bidirectional ring.
  function automatic int ring_hops(input int a, input int b, input int n);
    int d;
    d = (a > b) ? a - b : b - a;
    return (n - d < d) ? n - d : d;
  endfunction

  // Spread of a set of load values compared against a threshold.
  function automatic logic spread_exceeds(input int hi, input int lo, input int thr);
    return (hi - lo) > thr;
  endfunction

endpackage

// File: rtl/steer_cost.sv
module steer_cost
  import steer_pkg::*;
#(
  parameter int NCLU = 4,
  parameter int NSRC = 2,
  parameter int CSTW = 3,
  parameter int CPW  = 2
) (
  input  logic [NSRC-1:0]      used,
  input  logic [NSRC*NCLU-1:0] loc_eff,
  input  logic                 topo_mode,
  output logic [NCLU*CSTW-1:0] cost,
  output logic [NCLU*CPW-1:0]  copies
);

  for (genvar c = 0; c < NCLU; c++) begin : g_clu
    logic [CSTW-1:0] cst;
    logic [CPW-1:0]  cpy;

    always_comb begin
      int ncopy;
      int far;
      int near;
      ncopy = 0;
      far   = 0;
      near  = NCLU;
      for (int s = 0; s < NSRC; s++) begin
        if (used[s] && !loc_eff[s*NCLU+c]) begin
          ncopy++;
          near = NCLU;
          for (int h = 0; h < NCLU; h++) begin
            if (loc_eff[s*NCLU+h] && (ring_hops(h, c, NCLU) < near))
              near = ring_hops(h, c, NCLU);
          end
          if (near > far) far = near;
        end
      end
      cpy = CPW'(ncopy);
      cst = topo_mode ? CSTW'(far) : CSTW'(ncopy);
    end

    assign cost[c*CSTW +: CSTW] = cst;
    assign copies[c*CPW +: CPW] = cpy;
  end

endmodule

// File: rtl/steer_imbal.sv
module steer_imbal
  import steer_pkg::*;
#(
  parameter int NCLU = 4,
  parameter int LDW  = 6,
  parameter int THW  = 6
) (
  input  logic [NCLU*LDW-1:0] loads,
  input  logic [THW-1:0]      thr,
  output logic [LDW-1:0]      spread,
  output logic                over
);

  logic [LDW-1:0] hi, lo;

  always_comb begin
    hi = loads[0 +: LDW];
    lo = loads[0 +: LDW];
    for (int c = 1; c < NCLU; c++) begin
      if (loads[c*LDW +: LDW] > hi) hi = loads[c*LDW +: LDW];
      if (loads[c*LDW +: LDW] < lo) lo = loads[c*LDW +: LDW];
    end
  end

  assign spread = hi - lo;
  assign over   = spread_exceeds(int'(hi), int'(lo), int'(thr));

endmodule

// File: rtl/steer_pick.sv
module steer_pick #(
  parameter int NCLU = 4,
  parameter int LDW  = 6,
  parameter int CIDW = 2
) (
  input  logic [NCLU-1:0]     cand,
  input  logic [NCLU*LDW-1:0] loads,
  output logic [CIDW-1:0]     pick
);

  always_comb begin
    logic           found;
    logic [LDW-1:0] best;
    found = 1'b0;
    best  = '0;
    pick  = '0;
    // Ascending scan with strict less-than keeps the lowest index on ties.
    for (int c = 0; c < NCLU; c++) begin
      if (cand[c] && (!found || (loads[c*LDW +: LDW] < best))) begin
        found = 1'b1;
        best  = loads[c*LDW +: LDW];
        pick  = CIDW'(c);
      end
    end
  end

endmodule

// File: rtl/cluster_steer.sv
module cluster_steer #(
  parameter int NCLU = 4,
  parameter int NSRC = 2,
  parameter int LDW  = 6,
  parameter int THW  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [NSRC-1:0]                src_used,
  input  logic [NSRC-1:0]                src_rdy,
  input  logic [NSRC*NCLU-1:0]           src_loc,
  input  logic [NSRC*$clog2(NCLU)-1:0]   src_prod,
  input  logic [NCLU*LDW-1:0]            loads,
  input  logic [THW-1:0]                 imb_thr,
  input  logic                           topo_mode,
  output logic                           out_valid,
  output logic [$clog2(NCLU)-1:0]        out_cluster,
  output logic [$clog2(NSRC+1)-1:0]      out_copies
);

  localparam int CIDW = $clog2(NCLU);
  localparam int CPW  = $clog2(NSRC + 1);
  localparam int CSTW = $clog2(NCLU + NSRC + 1);

  // Named internal events, visible to the bound checker.
  logic                 any_used;
  logic                 wait_any;
  logic [CIDW-1:0]      wait_clu;
  logic [NSRC*NCLU-1:0] loc_eff;
  logic [NCLU*CSTW-1:0] cost;
  logic [NCLU*CPW-1:0]  copies;
  logic [NCLU-1:0]      cost_mask;
  logic [NCLU-1:0]      cand_mask;
  logic [LDW-1:0]       spread;
  logic                 over_thr;
  logic [CIDW-1:0]      pick_idx;
  logic [CPW-1:0]       copy_sel;

  // Operand status: first waiting operand and effective holder masks.
  always_comb begin
    any_used = |src_used;
    wait_any = 1'b0;
    wait_clu = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (src_used[s] && !src_rdy[s]) begin
        wait_any = 1'b1;
        wait_clu = src_prod[s*CIDW +: CIDW];
      end
    end
    for (int s = 0; s < NSRC; s++) begin
      if (src_rdy[s]) loc_eff[s*NCLU +: NCLU] = src_loc[s*NCLU +: NCLU];
      else            loc_eff[s*NCLU +: NCLU] = NCLU'(1) << src_prod[s*CIDW +: CIDW];
    end
  end

  steer_cost #(
    .NCLU(NCLU), .NSRC(NSRC), .CSTW(CSTW), .CPW(CPW)
  ) u_cost (
    .used      (src_used),
    .loc_eff   (loc_eff),
    .topo_mode (topo_mode),
    .cost      (cost),
    .copies    (copies)
  );

  steer_imbal #(
    .NCLU(NCLU), .LDW(LDW), .THW(THW)
  ) u_imbal (
    .loads  (loads),
    .thr    (imb_thr),
    .spread (spread),
    .over   (over_thr)
  );

  // Clusters sharing the minimum locality cost.
  always_comb begin
    logic [CSTW-1:0] min_cost;
    min_cost = '1;
    for (int c = 0; c < NCLU; c++)
      if (cost[c*CSTW +: CSTW] < min_cost) min_cost = cost[c*CSTW +: CSTW];
    for (int c = 0; c < NCLU; c++)
      cost_mask[c] = (cost[c*CSTW +: CSTW] == min_cost);
  end

  // Candidate set: override, then producer, then cost.
  always_comb begin
    if (over_thr || !any_used) cand_mask = '1;
    else if (wait_any)         cand_mask = NCLU'(1) << wait_clu;
    else                       cand_mask = cost_mask;
  end

  steer_pick #(
    .NCLU(NCLU), .LDW(LDW), .CIDW(CIDW)
  ) u_pick (
    .cand  (cand_mask),
    .loads (loads),
    .pick  (pick_idx)
  );

  assign copy_sel = copies[pick_idx*CPW +: CPW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_cluster <= '0;
      out_copies  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cluster <= pick_idx;
        out_copies  <= copy_sel;
      end
    end
  end

endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int NCLU = 4,
  parameter int NSRC = 2,
  parameter int LDW  = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       out_valid,
  input logic [$clog2(NCLU)-1:0]    out_cluster,
  input logic [$clog2(NSRC+1)-1:0]  out_copies,
  input logic [NCLU*LDW-1:0]        loads,
  input logic [NCLU-1:0]            cand_mask,
  input logic [$clog2(NCLU)-1:0]    pick_idx,
  input logic                       over_thr,
  input logic                       wait_any,
  input logic                       any_used
);

  localparam int CIDW = $clog2(NCLU);

  logic [LDW-1:0] pick_load;
  assign pick_load = loads[pick_idx*LDW +: LDW];

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_cluster) && $stable(out_copies)));

  p_reg_pick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_cluster == $past(pick_idx)));

  p_in_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> cand_mask[pick_idx]);

  p_override_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && over_thr) |-> (&cand_mask));

  p_no_operand_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_used) |-> (&cand_mask));

  p_wait_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !over_thr && wait_any) |-> ($countones(cand_mask) == 1));

  p_copy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_copies) <= NSRC));

  for (genvar c = 0; c < NCLU; c++) begin : g_load
    p_min_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cand_mask[c]) |-> (pick_load <= loads[c*LDW +: LDW]));

    p_tie_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cand_mask[c] && (loads[c*LDW +: LDW] == pick_load))
        |-> (pick_idx <= CIDW'(c)));
  end

endmodule

bind cluster_steer steer_chk #(
  .NCLU(NCLU), .NSRC(NSRC), .LDW(LDW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_cluster (out_cluster),
  .out_copies  (out_copies),
  .loads       (loads),
  .cand_mask   (cand_mask),
  .pick_idx    (pick_idx),
  .over_thr    (over_thr),
  .wait_any    (wait_any),
  .any_used    (any_used)
);

// File: tb/cluster_steer_bench.sv
`timescale 1ns/1ps
module cluster_steer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  src_used = '0;
  logic [1:0]  src_rdy = '0;
  logic [7:0]  src_loc = '0;
  logic [3:0]  src_prod = '0;
  logic [23:0] loads = '0;
  logic [5:0]  imb_thr = '0;
  logic        topo_mode = 1'b0;
  logic        out_valid;
  logic [1:0]  out_cluster;
  logic [1:0]  out_copies;

  int n_checks = 0;
  int n_fail   = 0;
  int last_cl  = 0;
  int last_cp  = 0;

  typedef struct {
    int    cl;
    int    cp;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  cluster_steer u_cluster_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_used(src_used), .src_rdy(src_rdy), .src_loc(src_loc),
    .src_prod(src_prod), .loads(loads), .imb_thr(imb_thr),
    .topo_mode(topo_mode), .out_valid(out_valid),
    .out_cluster(out_cluster), .out_copies(out_copies)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Ring hop count written as a modular difference.
  function automatic int hop(input int a, input int b);
    int h;
    h = (a - b + 4) % 4;
    return (h == 3) ? 1 : h;
  endfunction

  function automatic void model(input logic [1:0] u, input logic [1:0] r,
                                input logic [7:0] loc, input logic [3:0] pr,
                                input logic [23:0] ld, input logic [5:0] th,
                                input logic topo, output int cl, output int cp,
                                output string tag);
    int L[4];
    bit eff[2][4];
    bit cand[4];
    int cost[4];
    int mx, mn, best, wp;
    bit waitf;
    for (int c = 0; c < 4; c++) L[c] = int'(ld[c*6 +: 6]);
    mx = L[0]; mn = L[0];
    for (int c = 1; c < 4; c++) begin
      if (L[c] > mx) mx = L[c];
      if (L[c] < mn) mn = L[c];
    end
    for (int s = 0; s < 2; s++)
      for (int h = 0; h < 4; h++)
        eff[s][h] = r[s] ? loc[s*4+h] : (int'(pr[s*2 +: 2]) == h);
    waitf = 0; wp = 0;
    for (int s = 1; s >= 0; s--)
      if (u[s] && !r[s]) begin waitf = 1; wp = int'(pr[s*2 +: 2]); end
    if ((mx - mn) > int'(th)) begin
      for (int c = 0; c < 4; c++) cand[c] = 1;
      tag = "R7";
    end else if (u == 0) begin
      for (int c = 0; c < 4; c++) cand[c] = 1;
      tag = "R8";
    end else if (waitf) begin
      for (int c = 0; c < 4; c++) cand[c] = (c == wp);
      tag = "R5";
    end else begin
      best = 99;
      for (int c = 0; c < 4; c++) begin
        cost[c] = 0;
        for (int s = 0; s < 2; s++) begin
          if (u[s] && !eff[s][c]) begin
            if (topo) begin
              int nd;
              nd = 9;
              for (int h = 0; h < 4; h++)
                if (eff[s][h] && hop(c, h) < nd) nd = hop(c, h);
              if (nd > cost[c]) cost[c] = nd;
            end else cost[c]++;
          end
        end
        if (cost[c] < best) best = cost[c];
      end
      for (int c = 0; c < 4; c++) cand[c] = (cost[c] == best);
      tag = topo ? "R4" : "R3";
    end
    cl = -1;
    for (int c = 0; c < 4; c++)
      if (cand[c] && (cl < 0 || L[c] < L[cl])) cl = c;
    cp = 0;
    for (int s = 0; s < 2; s++) if (u[s] && !eff[s][cl]) cp++;
  endfunction

  // Driver: presents one instruction and pushes its expected result.
  task automatic send(input logic [1:0] u, input logic [1:0] r, input logic [7:0] loc,
                      input logic [3:0] pr, input logic [23:0] ld, input logic [5:0] th,
                      input logic topo);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; src_used = u; src_rdy = r; src_loc = loc;
    src_prod = pr; loads = ld; imb_thr = th; topo_mode = topo;
    model(u, r, loc, pr, ld, th, topo, e.cl, e.cp, e.tag);
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    src_used = $urandom_range(0, 3);
    loads = 24'($urandom);
  endtask

  // Monitor: pops one expectation per presented decision.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R1 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(out_cluster) == e.cl, {e.tag, "/R6 cluster"}, int'(out_cluster), e.cl);
          check(int'(out_copies) == e.cp, {e.tag, "/R9 copies"}, int'(out_copies), e.cp);
          last_cl = e.cl;
          last_cp = e.cp;
        end
      end
    end
  end

  function automatic logic [23:0] ld4(input int a, input int b, input int c, input int d);
    return {6'(d), 6'(c), 6'(b), 6'(a)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R2: reset values
    check(out_valid == 1'b0, "R2 out_valid", int'(out_valid), 0);
    check(out_cluster == 2'd0, "R2 out_cluster", int'(out_cluster), 0);
    check(out_copies == 2'd0, "R2 out_copies", int'(out_copies), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 with R6 tie: no operands, loads 5,3,3,9 -> cluster 1
    send(2'b00, 2'b00, 8'h00, 4'h0, ld4(5, 3, 3, 9), 6'd63, 1'b0);
    // R3: op0 at {2}, op1 at {2,3} -> cluster 2, no copies
    send(2'b11, 2'b11, {4'b1100, 4'b0100}, 4'h0, ld4(4, 4, 4, 4), 6'd63, 1'b0);
    // R3: op0 at {0}, op1 at {2}, loads 1,2,3,2 -> cluster 0, one copy
    send(2'b11, 2'b11, {4'b0100, 4'b0001}, 4'h0, ld4(1, 2, 3, 2), 6'd63, 1'b0);
    // R4: same operands in distance mode -> clusters 1/3 tie, pick 1, two copies
    send(2'b11, 2'b11, {4'b0100, 4'b0001}, 4'h0, ld4(1, 2, 3, 2), 6'd63, 1'b1);
    // R5: op1 waits on cluster 3, op0 at {1} -> cluster 3, one copy
    send(2'b11, 2'b01, {4'b0000, 4'b0010}, {2'd3, 2'd0}, ld4(2, 2, 2, 6), 6'd10, 1'b0);
    // R5: both wait, op0 on 2, op1 on 0 -> lowest operand wins: cluster 2
    send(2'b11, 2'b00, 8'h00, {2'd0, 2'd2}, ld4(1, 1, 9, 1), 6'd20, 1'b1);
    // R7: spread 30 > 5 -> least loaded cluster 1 despite holder at 3
    send(2'b01, 2'b01, 8'b0000_1000, 4'h0, ld4(20, 10, 30, 40), 6'd5, 1'b0);
    // R7 boundary: spread 2 == thr 2 -> locality keeps cluster 1
    send(2'b01, 2'b01, 8'b0000_0010, 4'h0, ld4(10, 12, 10, 10), 6'd2, 1'b0);
    // R8: unused op0 at {3} ignored, op1 at {1} -> cluster 1
    send(2'b10, 2'b11, {4'b0010, 4'b1000}, 4'h0, ld4(5, 5, 5, 0), 6'd63, 1'b0);
    idle();
    idle();
    idle();
    // R1: idle cycles leave the last decision in place
    check(out_valid == 1'b0, "R1 idle out_valid", int'(out_valid), 0);
    check(int'(out_cluster) == last_cl, "R1 hold cluster", int'(out_cluster), last_cl);
    check(int'(out_copies) == last_cp, "R1 hold copies", int'(out_copies), last_cp);

    // Mixed stream, R3 R4 R5 R6 R7 R8 R9 under varied patterns
    for (int i = 0; i < 400; i++) begin
      logic [7:0] loc;
      loc = 8'($urandom);
      if (loc[3:0] == 0) loc[$urandom_range(0, 3)] = 1'b1;
      if (loc[7:4] == 0) loc[4 + $urandom_range(0, 3)] = 1'b1;
      send(2'($urandom), ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b11, loc,
           4'($urandom), 24'($urandom), 6'($urandom_range(0, 63)), 1'($urandom));
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    idle();
    check(sb.size() == 0, "R1 pending results", sb.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule